// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a parameterised data cache placed between a processor load/store port and a slower next-level memory. Each request address is divided into three fields. The low bits give the byte position inside a block. The middle bits pick one set. The remaining high bits form the tag. All ways of the chosen set are compared in parallel, and on a hit the addressed bytes are returned without any memory traffic. The data capacity is sets times ways times block bytes; tags and status bits are not counted in it.

On a miss the controller picks a victim way. It prefers an invalid way, and falls back to the least-recently-used way when every way is valid. A dirty victim is copied back to memory as one block write. The missing block is then fetched as one block read. Writes follow the write-back and write-allocate policies: a write miss first fetches the block and then merges the write into the cached copy, and the line is marked dirty. A request is accepted only while the controller is idle. Each request receives exactly one response pulse, which carries either read data or an error flag.

Top module: `sa_wb_cache`

## Requirements
- R1: The byte offset is the low log2(BLOCK_BYTES) address bits, the set index is the next log2(SETS) bits, and the tag is the rest. With the defaults, addresses 64 bytes apart fall into the same set, and bits [5:4] select the set.
- R2: A request hits only when a way of its set is valid and holds an equal tag. A hit causes no memory transaction.
- R3: A miss in a set that still has an invalid way fills that way. It does not evict a valid line and issues no write-back.
- R4: When all ways of the set are valid, the victim is the least-recently-used way. Both a hit and a fill make the accessed way most-recently-used.
- R5: A write marks the line dirty. Evicting a dirty line first writes the whole block to its own block address (mem_we=1), and only then issues the fill read. Evicting a clean line issues no write.
- R6: A write miss fetches the block first and then merges the write. A later read returns the written bytes, and the other bytes keep their memory values.
- R7: req_size encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. Read data returns the bytes starting at the block offset in the low lanes, in little-endian order and zero-extended.
- R8: A request whose address is not a multiple of its width, or whose req_size is 3, returns resp_err=1. It starts no memory transaction and leaves the cache contents unchanged.
- R9: req_ready is high only while idle. Every accepted request yields exactly one single-cycle resp_valid pulse. mem_req, mem_we and mem_addr stay stable until mem_ack.
- R10: A synchronous active-low reset clears every valid and dirty bit. After reset, an access to a previously dirty line misses, is filled from memory without a write-back, and returns the memory data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (0 byte, 1 half, 2 word) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_BYTES*8 | Store data, low lanes used |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Request was misaligned or had an illegal size |
| resp_rdata | output | WORD_BYTES*8 | Load data, zero-extended |
| mem_req | output | 1 | Next-level transaction request |
| mem_we | output | 1 | 1 = block write-back, 0 = block fill |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | BLOCK_BYTES*8 | Victim block for write-back |
| mem_rdata | input | BLOCK_BYTES*8 | Fill block data |
| mem_ack | input | 1 | Transaction complete, fill data valid |

## Verification
The bench uses the default configuration: a 16-bit address, 16-byte blocks, 4 sets and 2 ways, for a capacity of 8 blocks. Because there are only two ways, three tags that share set 3 are enough to fill the set, force least-recently-used evictions of both clean and dirty lines, and show that an empty way is used before any eviction. A separate set takes the byte, half-word and misaligned accesses. A reset in the middle of the run shows that a write held only in a dirty line is discarded.

// File: rtl/cache_pkg.sv
// Shared types for the set-associative cache.
// Assumes: nothing beyond standard SystemVerilog.
package cache_pkg;

    // Controller states: miss path is LOOKUP -> WRITEBACK (dirty only) -> FILL -> RESPOND
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_FILL,
        ST_RESPOND
    } cache_state_e;

    localparam int SIZE_W = 2;

endpackage

// File: rtl/cache_tag_match.sv
// Compares the request tag against every way of one set in parallel.
// Assumes: at most one way holds a given valid tag.
module cache_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 10,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]      req_tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);

    // One comparator per way
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_valid[g] && (way_tags[g*TAG_W +: TAG_W] == req_tag);
    end

    assign hit = |hit_vec;

    // Encode the matching way as an index
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_victim_sel.sv
// Picks the way to replace: lowest-numbered invalid way, otherwise the oldest.
// Assumes: ages within a set are a permutation of 0..WAYS-1.
module cache_victim_sel #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS*WAY_W-1:0] way_ages,
    output logic [WAY_W-1:0]      victim
);

    // Oldest way first, then any invalid way overrides (lowest index wins)
    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_ages[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
        end
        for (int w = WAYS-1; w >= 0; w--) begin
            if (!way_valid[w]) victim = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_lru_ages.sv
// Per-set recency ages: 0 is most recent, WAYS-1 is least recent.
// Assumes: touch_way is a legal way index when touch_en is high.
module cache_lru_ages #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  touch_en,
    input  logic [IDX_W-1:0]      touch_set,
    input  logic [WAY_W-1:0]      touch_way,
    input  logic [IDX_W-1:0]      rd_set,
    output logic [WAYS*WAY_W-1:0] rd_ages
);

    logic [WAYS*WAY_W-1:0] age_q [SETS];
    logic [WAYS*WAY_W-1:0] touched;
    logic [WAYS*WAY_W-1:0] next_ages;
    logic [WAY_W-1:0]      ref_age;
    logic [WAY_W-1:0]      cur_age;

    // Ages after making touch_way the most recent in its set
    always_comb begin
        touched   = age_q[touch_set];
        ref_age   = touched[touch_way*WAY_W +: WAY_W];
        next_ages = touched;
        for (int w = 0; w < WAYS; w++) begin
            cur_age = touched[w*WAY_W +: WAY_W];
            if (WAY_W'(w) == touch_way)  next_ages[w*WAY_W +: WAY_W] = '0;
            else if (cur_age < ref_age)  next_ages[w*WAY_W +: WAY_W] = cur_age + 1'b1;
        end
    end

    // Age storage: distinct ages at reset, update on touch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w*WAY_W +: WAY_W] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            age_q[touch_set] <= next_ages;
        end
    end

    assign rd_ages = age_q[rd_set];

endmodule

// File: rtl/cache_lane_mux.sv
// Extracts the addressed bytes from a block and merges store data into it.
// Assumes: offset + width does not cross the block (checked by the caller).
module cache_lane_mux #(
    parameter int BLOCK_BYTES = 16,
    parameter int WORD_BYTES  = 4,
    parameter int OFF_W       = 4
) (
    input  logic [BLOCK_BYTES*8-1:0] block_in,
    input  logic [OFF_W-1:0]         offset,
    input  logic [1:0]               size,
    input  logic [WORD_BYTES*8-1:0]  wdata,
    output logic [WORD_BYTES*8-1:0]  rdata,
    output logic [BLOCK_BYTES*8-1:0] block_merged
);

    logic [BLOCK_BYTES*8-1:0] shifted;
    int nbytes;

    assign nbytes = 1 << size;

    // Read lanes: shift the target byte down to lane 0, zero unused lanes
    always_comb begin
        shifted = block_in >> {offset, 3'b000};
        for (int b = 0; b < WORD_BYTES; b++) begin
            rdata[b*8 +: 8] = (b < nbytes) ? shifted[b*8 +: 8] : 8'h00;
        end
    end

    // Write merge: replace only the bytes covered by the access
    always_comb begin
        block_merged = block_in;
        for (int i = 0; i < BLOCK_BYTES; i++) begin
            if (i >= int'(offset) && i < int'(offset) + nbytes && i - int'(offset) < WORD_BYTES) begin
                block_merged[i*8 +: 8] = wdata[(i - int'(offset))*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/sa_wb_cache.sv
// Set-associative write-back, write-allocate data cache controller.
// Assumes: one outstanding request; memory returns a whole block per fill;
// SETS, BLOCK_BYTES and WORD_BYTES are powers of two, SETS >= 2.
module sa_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BLOCK_BYTES = 16,
    parameter int SETS        = 4,
    parameter int WAYS        = 2,
    parameter int WORD_BYTES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_we,
    input  logic [1:0]               req_size,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [WORD_BYTES*8-1:0]  req_wdata,
    output logic                     resp_valid,
    output logic                     resp_err,
    output logic [WORD_BYTES*8-1:0]  resp_rdata,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [BLOCK_BYTES*8-1:0] mem_wdata,
    input  logic [BLOCK_BYTES*8-1:0] mem_rdata,
    input  logic                     mem_ack
);

    localparam int OFF_W    = $clog2(BLOCK_BYTES);
    localparam int IDX_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int BLOCK_W  = BLOCK_BYTES * 8;
    localparam int WORD_W   = WORD_BYTES * 8;
    localparam int MAX_SIZE = $clog2(WORD_BYTES);

    cache_state_e state_q;

    // Latched request
    logic              r_we;
    logic [1:0]        r_size;
    logic [ADDR_W-1:0] r_addr;
    logic [WORD_W-1:0] r_wdata;
    logic [WAY_W-1:0]  vict_q;

    // Line storage
    logic [BLOCK_W-1:0] data_arr [SETS][WAYS];
    logic [TAG_W-1:0]   tag_arr  [SETS][WAYS];
    logic [WAYS-1:0]    valid_q  [SETS];
    logic [WAYS-1:0]    dirty_q  [SETS];

    // Address fields (R1)
    logic [OFF_W-1:0] r_off;
    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    assign r_off = r_addr[OFF_W-1:0];
    assign r_idx = r_addr[OFF_W +: IDX_W];
    assign r_tag = r_addr[ADDR_W-1 -: TAG_W];

    // Selected-set views
    logic [WAYS-1:0]       set_valid;
    logic [WAYS-1:0]       set_dirty;
    logic [WAYS*TAG_W-1:0] set_tags;
    assign set_valid = valid_q[r_idx];
    assign set_dirty = dirty_q[r_idx];
    for (genvar g = 0; g < WAYS; g++) begin : g_tags
        assign set_tags[g*TAG_W +: TAG_W] = tag_arr[r_idx][g];
    end

    // Alignment and width check (R8)
    logic [OFF_W-1:0] align_mask;
    logic             misaligned;
    assign align_mask = OFF_W'((32'd1 << r_size) - 32'd1);
    assign misaligned = (int'(r_size) > MAX_SIZE) || ((r_off & align_mask) != '0);

    logic [WAYS-1:0]       hit_vec;
    logic                  hit;
    logic [WAY_W-1:0]      hit_way;
    logic [WAYS*WAY_W-1:0] set_ages;
    logic [WAY_W-1:0]      victim;
    logic [WORD_W-1:0]     lane_rdata;
    logic [BLOCK_W-1:0]    lane_merged;

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .way_valid (set_valid),
        .way_tags  (set_tags),
        .req_tag   (r_tag),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cache_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .way_valid (set_valid),
        .way_ages  (set_ages),
        .victim    (victim)
    );

    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    assign touch_en  = (state_q == ST_FILL && mem_ack) || (state_q == ST_RESPOND && !misaligned);
    assign touch_way = (state_q == ST_FILL) ? vict_q : hit_way;

    cache_lru_ages #(.SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_set (r_idx),
        .touch_way (touch_way),
        .rd_set    (r_idx),
        .rd_ages   (set_ages)
    );

    cache_lane_mux #(.BLOCK_BYTES(BLOCK_BYTES), .WORD_BYTES(WORD_BYTES), .OFF_W(OFF_W)) u_lane (
        .block_in     (data_arr[r_idx][hit_way]),
        .offset       (r_off),
        .size         (r_size),
        .wdata        (r_wdata),
        .rdata        (lane_rdata),
        .block_merged (lane_merged)
    );

    // Memory port driven straight from the state
    assign req_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_FILL);
    assign mem_we    = (state_q == ST_WRITEBACK);
    assign mem_addr  = (state_q == ST_WRITEBACK) ? {tag_arr[r_idx][vict_q], r_idx, {OFF_W{1'b0}}}
                                                 : {r_tag, r_idx, {OFF_W{1'b0}}};
    assign mem_wdata = data_arr[r_idx][vict_q];

    // Controller sequence and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            r_we    <= 1'b0;
            r_size  <= '0;
            r_addr  <= '0;
            r_wdata <= '0;
            vict_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    r_we    <= req_we;
                    r_size  <= req_size;
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    state_q <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    if (misaligned || hit) begin
                        state_q <= ST_RESPOND;
                    end else begin
                        vict_q  <= victim;
                        state_q <= (set_valid[victim] && set_dirty[victim]) ? ST_WRITEBACK : ST_FILL;
                    end
                end
                ST_WRITEBACK: if (mem_ack) state_q <= ST_FILL;
                ST_FILL:      if (mem_ack) state_q <= ST_RESPOND;
                ST_RESPOND:   state_q <= ST_IDLE;
                default:      state_q <= ST_IDLE;
            endcase
        end
    end

    // Response registers: one pulse per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= (state_q == ST_RESPOND);
            if (state_q == ST_RESPOND) begin
                resp_err   <= misaligned;
                resp_rdata <= (misaligned || r_we) ? '0 : lane_rdata;
            end
        end
    end

    // Valid and dirty bits: set on fill or store, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (state_q == ST_FILL && mem_ack) begin
            valid_q[r_idx][vict_q] <= 1'b1;
            dirty_q[r_idx][vict_q] <= 1'b0;
        end else if (state_q == ST_RESPOND && !misaligned && r_we) begin
            dirty_q[r_idx][hit_way] <= 1'b1;
        end
    end

    // Data and tag storage: fill writes the block, store merges bytes
    always_ff @(posedge clk) begin
        if (state_q == ST_FILL && mem_ack) begin
            data_arr[r_idx][vict_q] <= mem_rdata;
            tag_arr[r_idx][vict_q]  <= r_tag;
        end else if (state_q == ST_RESPOND && !misaligned && r_we) begin
            data_arr[r_idx][hit_way] <= lane_merged;
        end
    end

    // ---------------- assertions ----------------
    logic [WAYS*SETS-1:0] valid_flat;
    for (genvar s = 0; s < SETS; s++) begin : g_vflat
        assign valid_flat[s*WAYS +: WAYS] = valid_q[s];
    end

    // R2: no two ways of a set match the same tag
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> $onehot0(hit_vec));

    // R3: while a way is empty, the chosen victim is empty
    a_r3_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !hit && !misaligned && !(&set_valid)) |-> !set_valid[victim]);

    // R6: after a fill the request is served from a now-present line
    a_r6_respond_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESPOND && !misaligned) |-> hit);

    // R5: a completed write-back is followed by the fill read
    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R9: memory request held steady until acknowledged
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R9: response is a single-cycle pulse, issued while idle
    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    a_r9_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R8: an error response comes with no memory activity
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> !mem_req);

    // R10: reset leaves no valid line
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (valid_flat == '0));

endmodule

// File: tb/sa_wb_cache_bench.sv
// Self-checking bench for sa_wb_cache with a sparse block memory model.
module sa_wb_cache_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_we = 1'b0;
    logic [1:0]   req_size = 2'd0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic         resp_err;
    logic [31:0]  resp_rdata;
    logic         mem_req;
    logic         mem_we;
    logic [15:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    int fill_cnt = 0;
    int wb_cnt = 0;
    int wait_cnt = 0;

    always #5 clk = ~clk;

    sa_wb_cache #(.ADDR_W(16), .BLOCK_BYTES(16), .SETS(4), .WAYS(2), .WORD_BYTES(4)) u_sa_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory contents: written bytes, else a fixed function of the address
    logic [7:0] backing [int];
    logic [7:0] shadow  [int];

    function automatic logic [7:0] init_byte(int a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] back_byte(int a);
        return backing.exists(a) ? backing[a] : init_byte(a);
    endfunction

    function automatic logic [7:0] exp_byte(int a);
        return shadow.exists(a) ? shadow[a] : back_byte(a);
    endfunction

    // Memory responder: acknowledge after two waiting cycles
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            wait_cnt++;
            if (wait_cnt == 2) begin
                if (mem_we) begin
                    for (int i = 0; i < 16; i++) backing[int'(mem_addr) + i] = mem_wdata[i*8 +: 8];
                    wb_cnt++;
                end else begin
                    for (int i = 0; i < 16; i++) mem_rdata[i*8 +: 8] = back_byte(int'(mem_addr) + i);
                    fill_cnt++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One request through the port; also checks R9 ready and pulse behaviour
    task automatic run_req(input logic we, input logic [1:0] size, input logic [15:0] addr,
                           input logic [31:0] wdata, output logic [31:0] rdata,
                           output logic err, output int nf, output int nw);
        int f0;
        int w0;
        f0 = fill_cnt;
        w0 = wb_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_size = size; req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
        while (!resp_valid) @(negedge clk);
        rdata = resp_rdata;
        err   = resp_err;
        nf    = fill_cnt - f0;
        nw    = wb_cnt - w0;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9", "single response pulse", 64'(resp_valid), 64'd0);
        if (we && !err) begin
            for (int i = 0; i < (1 << size); i++) shadow[int'(addr) + i] = wdata[i*8 +: 8];
        end
    endtask

    function automatic logic [31:0] exp_read(logic [15:0] addr, logic [1:0] size);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < (1 << size); i++) v[i*8 +: 8] = exp_byte(int'(addr) + i);
        return v;
    endfunction

    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [1:0]  fills;
        logic [1:0]  wbs;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    // Set 3 tags A=0x1830 B=0x1870 C=0x18B0 (R1: 64 bytes apart share a set)
    localparam vec_t VECS [17] = '{
        '{1'b0, 2'd2, 16'h1830, 32'h0,        2'd1, 2'd0, 1'b0, 4'd1},  // R1 cold miss A -> way 0
        '{1'b0, 2'd2, 16'h1874, 32'h0,        2'd1, 2'd0, 1'b0, 4'd3},  // R3 B fills empty way
        '{1'b0, 2'd2, 16'h1838, 32'h0,        2'd0, 2'd0, 1'b0, 4'd2},  // R2 A still present, hit
        '{1'b1, 2'd2, 16'h1830, 32'hDEADBEEF, 2'd0, 2'd0, 1'b0, 4'd5},  // R5 write hit marks A dirty
        '{1'b0, 2'd2, 16'h18B0, 32'h0,        2'd1, 2'd0, 1'b0, 4'd4},  // R4 C evicts LRU B (clean)
        '{1'b0, 2'd2, 16'h1870, 32'h0,        2'd1, 2'd1, 1'b0, 4'd5},  // R5 B evicts dirty A, write-back
        '{1'b0, 2'd2, 16'h1830, 32'h0,        2'd1, 2'd0, 1'b0, 4'd4},  // R4 A evicts clean C, reads DEADBEEF
        '{1'b1, 2'd0, 16'h2004, 32'h000000AB, 2'd1, 2'd0, 1'b0, 4'd6},  // R6 byte write miss allocates
        '{1'b0, 2'd2, 16'h2004, 32'h0,        2'd0, 2'd0, 1'b0, 4'd6},  // R6 merged byte plus memory bytes
        '{1'b0, 2'd1, 16'h2006, 32'h0,        2'd0, 2'd0, 1'b0, 4'd7},  // R7 half read
        '{1'b0, 2'd0, 16'h2007, 32'h0,        2'd0, 2'd0, 1'b0, 4'd7},  // R7 byte read zero-extended
        '{1'b0, 2'd1, 16'h2005, 32'h0,        2'd0, 2'd0, 1'b1, 4'd8},  // R8 odd half
        '{1'b1, 2'd2, 16'h2002, 32'h12345678, 2'd0, 2'd0, 1'b1, 4'd8},  // R8 misaligned word store
        '{1'b0, 2'd3, 16'h2000, 32'h0,        2'd0, 2'd0, 1'b1, 4'd8},  // R8 illegal size
        '{1'b0, 2'd2, 16'h2004, 32'h0,        2'd0, 2'd0, 1'b0, 4'd8},  // R8 line untouched by errors
        '{1'b1, 2'd1, 16'h200A, 32'h00001234, 2'd0, 2'd0, 1'b0, 4'd7},  // R7 half write hit
        '{1'b0, 2'd2, 16'h2008, 32'h0,        2'd0, 2'd0, 1'b0, 4'd7}   // R7 word shows half at offset 2
    };

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          nf;
        int          nw;

        // Reset state (R9, R10)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready after reset", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R9", "no response after reset", 64'(resp_valid), 64'd0);
        chk(mem_req == 1'b0, "R10", "memory idle after reset", 64'(mem_req), 64'd0);

        // Vector table walk
        for (int k = 0; k < 17; k++) begin
            vec_t v;
            string rq;
            v  = VECS[k];
            rq = $sformatf("R%0d", v.req);
            run_req(v.we, v.size, v.addr, v.wdata, rd, er, nf, nw);
            chk(er == v.err, rq, $sformatf("err vec %0d", k), 64'(er), 64'(v.err));
            chk(nf == int'(v.fills), rq, $sformatf("fills vec %0d", k), 64'(nf), 64'(v.fills));
            chk(nw == int'(v.wbs), rq, $sformatf("write-backs vec %0d", k), 64'(nw), 64'(v.wbs));
            if (!v.we && !v.err) begin
                chk(rd == exp_read(v.addr, v.size), rq, $sformatf("rdata vec %0d", k),
                    64'(rd), 64'(exp_read(v.addr, v.size)));
            end
        end

        // R5: the evicted dirty block landed at A's block address in memory
        chk(back_byte(16'h1830) == 8'hEF && back_byte(16'h1833) == 8'hDE, "R5",
            "written-back bytes", 64'({back_byte(16'h1833), back_byte(16'h1830)}), 64'hDEEF);

        // R10: dirty data is dropped by reset, line refetched without write-back
        run_req(1'b1, 2'd2, 16'h1830, 32'h11111111, rd, er, nf, nw);
        chk(nf == 0 && nw == 0, "R5", "store hit quiet", 64'(nf + nw), 64'd0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        shadow.delete();
        run_req(1'b0, 2'd2, 16'h1830, 32'h0, rd, er, nf, nw);
        chk(nf == 1, "R10", "refill after reset", 64'(nf), 64'd1);
        chk(nw == 0, "R10", "no write-back after reset", 64'(nw), 64'd0);
        chk(rd == 32'hDEADBEEF, "R10", "memory data after reset", 64'(rd), 64'hDEADBEEF);

        // R3 / R4 in set 1 after reset: two fills without eviction, then LRU
        run_req(1'b0, 2'd2, 16'h0010, 32'h0, rd, er, nf, nw);
        run_req(1'b0, 2'd2, 16'h0050, 32'h0, rd, er, nf, nw);
        chk(nw == 0 && nf == 1, "R3", "second way filled", 64'(nf), 64'd1);
        run_req(1'b0, 2'd0, 16'h0013, 32'h0, rd, er, nf, nw);
        chk(nf == 0, "R4", "hit refreshes first way", 64'(nf), 64'd0);
        run_req(1'b0, 2'd2, 16'h0090, 32'h0, rd, er, nf, nw);
        run_req(1'b0, 2'd2, 16'h0010, 32'h0, rd, er, nf, nw);
        chk(nf == 0, "R4", "recent way survived eviction", 64'(nf), 64'd0);
        chk(rd == exp_read(16'h0010, 2'd2), "R2", "hit data", 64'(rd), 64'(exp_read(16'h0010, 2'd2)));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule